// File: doc/BRIEF.md
# Serial Converter Frame and Power-Down Sequencer

This block is the digital control side of a serial sampling converter. It watches a serial clock with a faster system clock and counts its falling edges into conversion frames of sixteen edges. During each frame it shifts in a sixteen-bit configuration word and shifts out a ten-bit conversion result. The word collected in one frame is committed after that frame's sixteenth edge and governs the next frame. The conversion itself is outside the block: a ten-bit value on `conv_data` is captured when a frame starts, and the committed channel number is presented on `chan_sel` so that the analog side can supply the matching sample.

The block also sequences two power-down schemes and raises flags for the comparator, the clock input buffer and the reference. Automatic power-down follows a frame when no new frame starts at once. In frame-sync mode that means frame sync is low on the seventeenth edge. In microprocessor mode, where frame sync is held high, it means the serial clock stays idle for `STOP_LIMIT` system clocks. The automatic scheme resumes on the first clock or frame sync. Software power-down is requested by a bit in the word. It takes effect at the start of the following frame, wipes the configuration, and needs sixteen serial edges to recover.

States: IDLE (powered, waiting for a frame start), FRAME (counting edges 1 to 16), AUTO_PD, SOFT_PD, WAKE (16-edge recovery). Transitions are named as follows. IDLE→FRAME is a start edge. FRAME→FRAME is a step or a back-to-back start. FRAME→AUTO_PD is a missed sync or a clock stop with automatic power-down enabled. FRAME→IDLE is a missed sync with automatic power-down disabled. FRAME→SOFT_PD is a boundary with the software bit set. AUTO_PD→IDLE is frame sync rising in frame-sync mode. AUTO_PD→FRAME is a start edge. SOFT_PD→WAKE is a start edge. WAKE→IDLE is the sixteenth recovery edge.

Top module: `adc_frame_seq`

## Requirements
- R1: A frame begins on a serial-clock falling edge that sees `fsync` high and spans exactly 16 falling edges. An edge arriving after the 16th ends that frame.
- R2: `sdin` is shifted in MSB first on each of the 16 edges of a frame. The complete word is committed after the 16th edge. From then on `chan_sel` equals word bits [2:0].
- R3: `conv_data` is captured on the first edge of a frame and driven on `sdout` MSB first. After edge k of the frame (k = 1..10), `sdout` equals bit 10−k. After edges 11 to 16 it is 0.
- R4: In frame-sync mode (`mode_dsp`=1), `fsync` low on the 17th edge ends the frame. If bit 4 of the committed word is 0 (automatic power-down enabled), the block enters automatic power-down: `comp_pd`=1, `ref_pd`=0, `clkbuf_pd`=1. If bit 4 is 1, no flag rises.
- R5: In frame-sync mode, `fsync` going high ends automatic power-down within one system clock, with no serial edge needed. The next start edge begins a normal frame.
- R6: In microprocessor mode (`mode_dsp`=0), `STOP_LIMIT` system clocks without a falling edge after a complete frame enter automatic power-down when bit 4 is 0. The flags are then `comp_pd`=1, `ref_pd`=0, `clkbuf_pd`=0. With bit 4 set to 1, no flag rises. The next falling edge exits and starts a frame.
- R7: When bit 15 of the committed word is 1, the next frame boundary enters software power-down instead of starting a frame. The boundary is either the next edge or a clock stop. In software power-down `comp_pd`=1 and `ref_pd`=1, `clkbuf_pd` follows `mode_dsp`, and the configuration returns to its default 0x0010, so `chan_sel`=0.
- R8: Software power-down exits on a falling edge with `fsync` high. Recovery then lasts 16 edges, counting that one. During recovery `comp_pd`=1 and `ref_pd`=0. After the 16th edge all flags are 0. Edges with `fsync` low do not exit software power-down in frame-sync mode.
- R9: `sdout` is 0 whenever the block is not in a frame, including all power-down states.
- R10: After reset all three flags are 0, `sdout` is 0 and `chan_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock; falling edges are counted |
| fsync | input | 1 | Frame sync; tie high in microprocessor mode |
| sdin | input | 1 | Serial configuration data in |
| mode_dsp | input | 1 | 1 = frame-sync mode, 0 = microprocessor mode |
| conv_data | input | RES_W | Conversion result supplied for the selected channel |
| sdout | output | 1 | Serial result out |
| chan_sel | output | CH_W | Committed channel select |
| comp_pd | output | 1 | Comparator powered down |
| clkbuf_pd | output | 1 | Clock input buffer powered down |
| ref_pd | output | 1 | Reference powered down |

## Verification
The hardest state to reach is the tail of software recovery. The bench must first commit a word with bit 15 set. It then has to reach the boundary edge with frame sync high and feed edges with frame sync low, which must leave the block powered down. Only then can it count the sixteen recovery edges, checking the flags before and after the last one. The bench also sets up the microprocessor-mode clock stop by holding `sclk` idle for more than `STOP_LIMIT` system clocks right after a sixteenth edge. It repeats that stop with automatic power-down disabled, to show that no flag rises.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FRAME,
        ST_AUTO_PD,
        ST_SOFT_PD,
        ST_WAKE
    } seq_state_t;
endpackage

// File: rtl/sfc_clk_watch.sv
module sfc_clk_watch #(
    parameter int STOP_LIMIT = 64,
    localparam int TW = $clog2(STOP_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic fall,
    output logic stop_hit
);
    logic          sclk_q;
    logic [TW-1:0] idle_q;

    assign fall     = sclk_q & ~sclk;
    assign stop_hit = !fall && (idle_q == TW'(STOP_LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            idle_q <= '0;
        end else begin
            sclk_q <= sclk;
            if (fall)
                idle_q <= '0;
            else if (idle_q != TW'(STOP_LIMIT))
                idle_q <= idle_q + 1'b1;
        end
    end

    // R6: idle timer saturates and reports a stop only once per idle spell
    a_r6_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q <= TW'(STOP_LIMIT));
    a_r6_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        stop_hit |=> !stop_hit);
endmodule

// File: rtl/sfc_cfg_shift.sv
module sfc_cfg_shift #(
    parameter int          CFG_W       = 16,
    parameter logic [15:0] CFG_DEFAULT = 16'h0010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sdin,
    input  logic             shift,
    input  logic             commit,
    input  logic             clear,
    output logic [CFG_W-1:0] cfg
);
    logic [CFG_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
            cfg  <= CFG_W'(CFG_DEFAULT);
        end else if (clear) begin
            sr_q <= '0;
            cfg  <= CFG_W'(CFG_DEFAULT);
        end else begin
            if (shift)
                sr_q <= {sr_q[CFG_W-2:0], sdin};
            if (commit)
                cfg <= {sr_q[CFG_W-2:0], sdin};
        end
    end

    // R2: the committed word only moves on a commit or a wipe
    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit || clear) |=> $stable(cfg));
endmodule

// File: rtl/sfc_res_shift.sv
module sfc_res_shift #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] data,
    input  logic             load,
    input  logic             shift,
    input  logic             clear,
    output logic             sdout
);
    logic [RES_W-1:0] res_q;

    assign sdout = res_q[RES_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            res_q <= '0;
        else if (load)
            res_q <= data;
        else if (clear)
            res_q <= '0;
        else if (shift)
            res_q <= {res_q[RES_W-2:0], 1'b0};
    end

    // R9: leaving a frame empties the output register
    a_r9_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !load) |=> (res_q == '0));
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
    import sfc_pkg::*;
#(
    parameter int          FRAME_LEN   = 16,
    parameter int          RES_W       = 10,
    parameter int          CH_W        = 3,
    parameter int          STOP_LIMIT  = 64,
    parameter int          AUTO_BIT    = 4,
    parameter int          SOFT_BIT    = 15,
    parameter logic [15:0] CFG_DEFAULT = 16'h0010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             fsync,
    input  logic             sdin,
    input  logic             mode_dsp,
    input  logic [RES_W-1:0] conv_data,
    output logic             sdout,
    output logic [CH_W-1:0]  chan_sel,
    output logic             comp_pd,
    output logic             clkbuf_pd,
    output logic             ref_pd
);
    localparam int CW    = $clog2(FRAME_LEN + 1);
    localparam int CFG_W = FRAME_LEN;

    seq_state_t       st_q, st_d;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic             fall, stop_hit;
    logic             start, step, commit, cfg_clr, res_clr;
    logic [CFG_W-1:0] cfg;
    logic             soft_req, auto_en, boundary_stop;

    assign soft_req      = cfg[SOFT_BIT];
    assign auto_en       = !cfg[AUTO_BIT];
    assign chan_sel      = cfg[CH_W-1:0];
    assign boundary_stop = stop_hit && !mode_dsp && (cnt_q == CW'(FRAME_LEN));

    sfc_clk_watch #(.STOP_LIMIT(STOP_LIMIT)) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .fall     (fall),
        .stop_hit (stop_hit)
    );

    sfc_cfg_shift #(.CFG_W(CFG_W), .CFG_DEFAULT(CFG_DEFAULT)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .sdin   (sdin),
        .shift  (start || step),
        .commit (commit),
        .clear  (cfg_clr),
        .cfg    (cfg)
    );

    sfc_res_shift #(.RES_W(RES_W)) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .data  (conv_data),
        .load  (start),
        .shift (step),
        .clear (res_clr),
        .sdout (sdout)
    );

    // next-state and counter logic
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        start   = 1'b0;
        step    = 1'b0;
        cfg_clr = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (fall && fsync)
                    start = 1'b1;
            end
            ST_FRAME: begin
                if (fall) begin
                    if (cnt_q != CW'(FRAME_LEN))
                        step = 1'b1;
                    else if (soft_req) begin
                        st_d    = ST_SOFT_PD;
                        cfg_clr = 1'b1;
                    end else if (fsync)
                        start = 1'b1;
                    else if (auto_en)
                        st_d = ST_AUTO_PD;
                    else
                        st_d = ST_IDLE;
                end else if (boundary_stop) begin
                    if (soft_req) begin
                        st_d    = ST_SOFT_PD;
                        cfg_clr = 1'b1;
                    end else if (auto_en)
                        st_d = ST_AUTO_PD;
                end
            end
            ST_AUTO_PD: begin
                if (fall && fsync)
                    start = 1'b1;
                else if (mode_dsp && fsync)
                    st_d = ST_IDLE;
            end
            ST_SOFT_PD: begin
                if (fall && fsync) begin
                    st_d  = ST_WAKE;
                    cnt_d = CW'(1);
                end
            end
            ST_WAKE: begin
                if (fall) begin
                    if (cnt_q == CW'(FRAME_LEN - 1)) begin
                        st_d  = ST_IDLE;
                        cnt_d = '0;
                    end else
                        cnt_d = cnt_q + 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
        if (start) begin
            st_d  = ST_FRAME;
            cnt_d = CW'(1);
        end
        if (step)
            cnt_d = cnt_q + 1'b1;
        if (st_q == ST_FRAME && st_d != ST_FRAME)
            cnt_d = '0;
    end

    assign commit  = step && (cnt_q == CW'(FRAME_LEN - 1));
    assign res_clr = (st_d != ST_FRAME);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // power-state outputs
    always_comb begin
        comp_pd   = 1'b0;
        clkbuf_pd = 1'b0;
        ref_pd    = 1'b0;
        unique case (st_q)
            ST_AUTO_PD: begin
                comp_pd   = 1'b1;
                clkbuf_pd = mode_dsp;
            end
            ST_SOFT_PD: begin
                comp_pd   = 1'b1;
                ref_pd    = 1'b1;
                clkbuf_pd = mode_dsp;
            end
            ST_WAKE: comp_pd = 1'b1;
            default: ;
        endcase
    end

    // R1: edge count never passes the frame length
    a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(FRAME_LEN));
    // R9: no result bits leave while the comparator is down
    a_r9_quiet_pd: assert property (@(posedge clk) disable iff (!rst_n)
        comp_pd |-> !sdout);
    // R7: reference never drops without the comparator
    a_r7_ref_with_comp: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pd |-> comp_pd);
    // R7: software power-down is only entered from a frame
    a_r7_entry_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_pd) |-> ($past(st_q) == ST_FRAME));
    // R4: clock buffer only sleeps together with the comparator
    a_r4_clkbuf_with_comp: assert property (@(posedge clk) disable iff (!rst_n)
        clkbuf_pd |-> comp_pd);
endmodule

// File: tb/adc_frame_seq_test.sv
module adc_frame_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b1;
    logic       fsync = 1'b1;
    logic       sdin = 1'b0;
    logic       mode_dsp = 1'b0;
    logic [9:0] conv_data;
    logic       sdout;
    logic [2:0] chan_sel;
    logic       comp_pd, clkbuf_pd, ref_pd;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adc_frame_seq uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync(fsync), .sdin(sdin),
        .mode_dsp(mode_dsp), .conv_data(conv_data), .sdout(sdout),
        .chan_sel(chan_sel), .comp_pd(comp_pd), .clkbuf_pd(clkbuf_pd),
        .ref_pd(ref_pd)
    );

    function automatic logic [9:0] conv_of(input logic [2:0] c);
        return {c, 7'(7'h2B + 7'(c) * 7'd9)};
    endfunction

    assign conv_data = conv_of(chan_sel);

    localparam logic [15:0] VEC [6] = '{16'h0013, 16'h2415, 16'h0017,
                                        16'h4C11, 16'h7A36, 16'h0012};

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic din, input logic fs, output logic sd);
        @(negedge clk);
        sclk = 1'b0; sdin = din; fsync = fs;
        repeat (3) @(negedge clk);
        sd = sdout;
        @(negedge clk);
        sclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic frame(input logic [15:0] word, input logic fs_rest,
                         output logic [9:0] got, output logic tail_ok);
        logic sd;
        tail_ok = 1'b1;
        for (int k = 0; k < 16; k++) begin
            tick(word[15-k], (k == 0) ? 1'b1 : fs_rest, sd);
            if (k < 10) got[9-k] = sd;
            else if (sd !== 1'b0) tail_ok = 1'b0;
        end
    endtask

    task automatic flags(input string req, input logic c, input logic b, input logic r);
        check(req, {13'b0, comp_pd, clkbuf_pd, ref_pd}, {13'b0, c, b, r});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [9:0] got;
        logic       ok, sd;
        logic [2:0] prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        flags("R10 flags", 1'b0, 1'b0, 1'b0);
        check("R10 sdout", {15'b0, sdout}, 16'h0);
        check("R10 chan_sel", {13'b0, chan_sel}, 16'h0);

        // R1 R2 R3 back-to-back frames, microprocessor mode
        prev = 3'd0;
        for (int i = 0; i < 6; i++) begin
            frame(VEC[i], 1'b1, got, ok);
            check("R3 result", {6'b0, got}, {6'b0, conv_of(prev)});
            check("R3 tail zero", {15'b0, ok}, 16'h1);
            check("R2 chan commit", {13'b0, chan_sel}, {13'b0, VEC[i][2:0]});
            prev = VEC[i][2:0];
        end
        frame(16'h0002, 1'b1, got, ok);
        check("R1 last result", {6'b0, got}, {6'b0, conv_of(prev)});

        // R6 clock stop with automatic power-down enabled
        repeat (80) @(negedge clk);
        flags("R6 auto pd up-mode", 1'b1, 1'b0, 1'b0);
        check("R9 sdout in pd", {15'b0, sdout}, 16'h0);
        frame(16'h0010, 1'b1, got, ok);
        check("R6 exit result", {6'b0, got}, {6'b0, conv_of(3'd2)});
        repeat (80) @(negedge clk);
        flags("R6 stop with auto off", 1'b0, 1'b0, 1'b0);

        // R4 R5 frame-sync mode
        mode_dsp = 1'b1;
        frame(16'h0005, 1'b0, got, ok);
        check("R1 dsp frame", {6'b0, got}, {6'b0, conv_of(3'd0)});
        tick(1'b0, 1'b0, sd);
        flags("R4 missed sync pd", 1'b1, 1'b1, 1'b0);
        check("R9 sdout auto pd", {15'b0, sd}, 16'h0);
        @(negedge clk); fsync = 1'b1;
        repeat (2) @(negedge clk);
        flags("R5 sync wake", 1'b0, 1'b0, 1'b0);
        frame(16'h0010, 1'b0, got, ok);
        check("R5 result after wake", {6'b0, got}, {6'b0, conv_of(3'd5)});
        tick(1'b0, 1'b0, sd);
        flags("R4 missed sync auto off", 1'b0, 1'b0, 1'b0);
        tick(1'b1, 1'b0, sd);
        check("R9 sdout idle", {15'b0, sd}, 16'h0);

        // R7 R8 software power-down
        frame(16'h8003, 1'b0, got, ok);
        check("R2 soft word chan", {13'b0, chan_sel}, 16'h3);
        tick(1'b0, 1'b1, sd);
        flags("R7 soft pd", 1'b1, 1'b1, 1'b1);
        check("R7 cfg wiped", {13'b0, chan_sel}, 16'h0);
        check("R9 sdout soft", {15'b0, sd}, 16'h0);
        tick(1'b0, 1'b0, sd);
        tick(1'b0, 1'b0, sd);
        flags("R8 no sync stays down", 1'b1, 1'b1, 1'b1);
        tick(1'b0, 1'b1, sd);
        flags("R8 recovering", 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 14; k++) tick(1'b0, 1'b0, sd);
        flags("R8 before 16th edge", 1'b1, 1'b0, 1'b0);
        tick(1'b0, 1'b0, sd);
        flags("R8 recovered", 1'b0, 1'b0, 1'b0);
        frame(16'h0010, 1'b0, got, ok);
        check("R8 result after recovery", {6'b0, got}, {6'b0, conv_of(3'd0)});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule